// File: doc/BRIEF.md
# Keyed-Clear Watchdog Counter

This block is a watchdog built from two counters in series. A base counter runs on every clock cycle and wraps after `2**BASE_W` cycles. Each wrap advances a main counter by one. Software writes a threshold into a register. Once the main counter has climbed to that threshold, the block raises a reset request and holds it until software writes the threshold register again.

Any write to the threshold register also restarts the main counter from zero, so that write is the usual way to service the watchdog. The base counter has its own clear register, and that register responds to one exact access only: the data word 0x0000_0055 written with all four byte enables set. Any other data value, or any narrower access, is dropped. A stray store therefore cannot realign the prescaler phase. A threshold of zero turns off overflow detection.

The reset input is asserted asynchronously and released through a synchroniser inside the block. The surrounding chip decides what the reset request triggers.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the threshold is zero and `ovf_o` is low, and it stays low while no register is written.
- R2: The base counter counts up by one every cycle and wraps after 2**BASE_W cycles. Each wrap advances the main counter by one, so the main counter reaches value T exactly T*2**BASE_W cycles after the base counter was cleared.
- R3: `ovf_o` goes high on the clock edge after the main counter equals a nonzero threshold T. With the base counter cleared at edge K and the main counter cleared at or after K within the same base period, that is edge K + T*2**BASE_W + 1. It then stays high until the threshold register is written.
- R4: A write to the threshold register (address THR_ADDR, any byte enables) loads `wr_data_i[MAIN_W-1:0]` as the threshold, clears the main counter and clears `ovf_o`, all on the same edge.
- R5: A write of exactly 32'h0000_0055 to the base-clear register (address BCLR_ADDR) with `wr_be_i` = 4'b1111 returns the base counter to zero on that edge, which moves the overflow edge to K' + T*2**BASE_W + 1 for that write edge K'.
- R6: A base-clear write with any `wr_be_i` other than 4'b1111 leaves the base counter and the overflow timing unchanged.
- R7: A full-word base-clear write with any data other than 32'h0000_0055 leaves the base counter and the overflow timing unchanged.
- R8: While the threshold is zero, `ovf_o` stays low whatever the main counter holds.
- R9: Writes to addresses other than THR_ADDR and BCLR_ADDR change neither counter nor the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr_i | input | ADDR_W | Register address of the write |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte enables of the write; 4'b1111 marks a full-word access |
| ovf_o | output | 1 | Reset request, held high after overflow |

## Verification
The bench builds the block with BASE_W = 4, so one base period is 16 cycles. With thresholds from 1 to 3, an overflow arrives within a few dozen cycles. That makes it practical to measure the exact overflow edge and to place key, partial-width and wrong-data writes in the middle of a base period. Each scenario compares the overflow edge against the key-write edge plus T*16 + 1. This checks the base-clear behaviour at the output port without reading any internal counter. MAIN_W stays at 12, so the minimum threshold of 1 and the disabling threshold of 0 are both exercised at full register width.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  localparam logic [DATA_W-1:0] BASE_KEY = 32'h0000_0055;
  localparam logic [BE_W-1:0]   FULL_BE  = '1;

  typedef struct packed {
    logic thr_wr;   // threshold register written
    logic key_clr;  // valid keyed clear of the base counter
  } wdt_cmd_t;

endpackage

// File: rtl/kwd_rst_sync.sv
module kwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  if (STAGES > 1) begin : g_multi
    always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
  end else begin : g_single
    always_comb sync_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/kwd_regif.sv
module kwd_regif
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] THR_ADDR  = 4'h0,
  parameter logic [ADDR_W-1:0] BCLR_ADDR = 4'h4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  output wdt_cmd_t          cmd_o
);

  logic hit_thr;
  logic hit_bclr;
  logic full_word;
  logic key_match;

  always_comb begin
    hit_thr   = wr_en_i && (wr_addr_i == THR_ADDR);
    hit_bclr  = wr_en_i && (wr_addr_i == BCLR_ADDR);
    full_word = (wr_be_i == FULL_BE);
    key_match = (wr_data_i == BASE_KEY);

    cmd_o.thr_wr  = hit_thr;
    cmd_o.key_clr = hit_bclr && full_word && key_match;
  end

  always_comb begin
    if (wr_en_i && (wr_addr_i == BCLR_ADDR) && (wr_be_i != FULL_BE)) begin
      assert_partial_ignored_R6 : assert (!cmd_o.key_clr);
    end
    if (wr_en_i && (wr_data_i != BASE_KEY)) begin
      assert_wrong_key_ignored_R7 : assert (!cmd_o.key_clr);
    end
    if (wr_en_i && (wr_addr_i != THR_ADDR) && (wr_addr_i != BCLR_ADDR)) begin
      assert_other_addr_ignored_R9 : assert (!cmd_o.thr_wr && !cmd_o.key_clr);
    end
  end

endmodule

// File: rtl/kwd_base_ctr.sv
module kwd_base_ctr #(
  parameter int unsigned BASE_W = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);

  localparam logic [BASE_W-1:0] BASE_MAX = '1;
  localparam logic [BASE_W-1:0] BASE_ONE = BASE_W'(1);

  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] base_d;

  always_comb begin
    if (clr_i) base_d = '0;
    else       base_d = base_q + BASE_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else         base_q <= base_d;
  end

  // a keyed clear suppresses the wrap of the period it cuts short
  assign tick_o = (base_q == BASE_MAX) && !clr_i;

  assert_key_clear_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (base_q == '0));

  assert_base_step_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (base_q == $past(base_q) + BASE_ONE));

  assert_tick_after_full_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (base_q == '0));

endmodule

// File: rtl/kwd_main_ctr.sv
module kwd_main_ctr #(
  parameter int unsigned MAIN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              thr_wr_i,
  input  logic [MAIN_W-1:0] thr_data_i,
  output logic              ovf_o
);

  localparam logic [MAIN_W-1:0] MAIN_ONE = MAIN_W'(1);

  logic [MAIN_W-1:0] thr_q, thr_d;
  logic [MAIN_W-1:0] main_q, main_d;
  logic              ovf_q, ovf_d;
  logic              armed;
  logic              at_limit;
  logic              thr_en;

  always_comb begin
    armed    = (thr_q != '0);
    at_limit = armed && (main_q == thr_q);
    thr_en   = thr_wr_i;
    thr_d    = thr_data_i;

    if (thr_wr_i)                 main_d = '0;
    else if (tick_i && !at_limit) main_d = main_q + MAIN_ONE;
    else                          main_d = main_q;

    if (thr_wr_i) ovf_d = 1'b0;
    else          ovf_d = ovf_q || at_limit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      main_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (thr_en) thr_q <= thr_d;
      main_q <= main_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;

  assert_thr_clear_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> (main_q == '0) && !ovf_q && (thr_q == $past(thr_data_i)));

  assert_ovf_hold_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !thr_wr_i) |=> ovf_q);

  assert_ovf_rise_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> ($past(main_q) == $past(thr_q)));

  assert_main_step_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!thr_wr_i && tick_i && !ovf_q && (main_q != thr_q)) |=> (main_q == $past(main_q) + MAIN_ONE));

  assert_zero_disables_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q == '0) |-> !ovf_q);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned BASE_W    = 20,
  parameter int unsigned MAIN_W    = 12,
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] THR_ADDR  = 4'h0,
  parameter logic [ADDR_W-1:0] BCLR_ADDR = 4'h4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [BE_W-1:0]      wr_be_i,
  output logic                 ovf_o
);

  logic     rst_sync_n;
  wdt_cmd_t cmd;
  logic     base_tick;

  kwd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  kwd_regif #(
    .ADDR_W    (ADDR_W),
    .THR_ADDR  (THR_ADDR),
    .BCLR_ADDR (BCLR_ADDR)
  ) u_regif (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_be_i   (wr_be_i),
    .cmd_o     (cmd)
  );

  kwd_base_ctr #(.BASE_W(BASE_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (cmd.key_clr),
    .tick_o (base_tick)
  );

  kwd_main_ctr #(.MAIN_W(MAIN_W)) u_main (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .tick_i     (base_tick),
    .thr_wr_i   (cmd.thr_wr),
    .thr_data_i (wr_data_i[MAIN_W-1:0]),
    .ovf_o      (ovf_o)
  );

  assert_reset_quiet_R1 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !ovf_o);

endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BASE_W     = 4;
  localparam int MAIN_W     = 12;
  localparam int ADDR_W     = 4;
  localparam int PERIOD     = 1 << BASE_W;
  localparam logic [ADDR_W-1:0] A_THR   = 4'h0;
  localparam logic [ADDR_W-1:0] A_BCLR  = 4'h4;
  localparam logic [ADDR_W-1:0] A_OTHER = 4'h8;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [3:0]        wr_be;
  logic              ovf;

  int edges;
  int last_edge;
  int n_vec;
  int n_bad;

  keyed_watchdog #(
    .BASE_W (BASE_W),
    .MAIN_W (MAIN_W),
    .ADDR_W (ADDR_W)
  ) u_keyed_watchdog (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .wr_be_i   (wr_be),
    .ovf_o     (ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial edges = 0;
  always @(posedge clk) edges <= edges + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
    last_edge = edges;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ovf(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      if (ovf) begin
        at = edges;
        break;
      end
      @(negedge clk);
    end
  endtask

  // key write first, then threshold; returns edge of the key write
  task automatic arm(input int t, output int kb);
    do_write(A_BCLR, 32'h55, 4'hF);
    kb = last_edge;
    do_write(A_THR, 32'(t), 4'hF);
  endtask

  task automatic t_reset;
    check("R1 ovf low after reset", int'(ovf), 0);
    idle(3 * PERIOD);
    check("R1 ovf stays low with zero threshold", int'(ovf), 0);
  endtask

  task automatic t_min_threshold;
    int kb, at;
    arm(1, kb);
    wait_ovf(4 * PERIOD, at);
    check("R3 overflow edge with threshold 1", at, kb + PERIOD + 1);
    idle(3 * PERIOD);
    check("R3 overflow held", int'(ovf), 1);
  endtask

  task automatic t_thr_clear;
    do_write(A_THR, 32'd2, 4'h1);
    check("R4 threshold write clears overflow", int'(ovf), 0);
  endtask

  task automatic t_long_threshold;
    int kb, at;
    arm(3, kb);
    wait_ovf(6 * PERIOD, at);
    check("R2 overflow edge with threshold 3", at, kb + 3 * PERIOD + 1);
  endtask

  task automatic t_key_clear;
    int kb, kb1, at;
    arm(2, kb);
    idle(6);
    do_write(A_BCLR, 32'h0000_0055, 4'hF);
    kb1 = last_edge;
    wait_ovf(6 * PERIOD, at);
    check("R5 keyed clear restarts base period", at, kb1 + 2 * PERIOD + 1);
  endtask

  task automatic t_partial;
    int kb, at;
    arm(2, kb);
    idle(6);
    do_write(A_BCLR, 32'h55, 4'h3);
    do_write(A_BCLR, 32'h55, 4'h1);
    wait_ovf(6 * PERIOD, at);
    check("R6 partial-width key ignored", at, kb + 2 * PERIOD + 1);
  endtask

  task automatic t_wrong_data;
    int kb, at;
    arm(2, kb);
    idle(6);
    do_write(A_BCLR, 32'h56, 4'hF);
    do_write(A_BCLR, 32'h0100_0055, 4'hF);
    wait_ovf(6 * PERIOD, at);
    check("R7 wrong key value ignored", at, kb + 2 * PERIOD + 1);
  endtask

  task automatic t_other_addr;
    int kb, at;
    arm(2, kb);
    idle(6);
    do_write(A_OTHER, 32'h55, 4'hF);
    do_write(A_OTHER, 32'd1, 4'hF);
    wait_ovf(6 * PERIOD, at);
    check("R9 other address ignored", at, kb + 2 * PERIOD + 1);
  endtask

  task automatic t_zero;
    do_write(A_THR, 32'd0, 4'hF);
    check("R8 zero threshold write clears ovf", int'(ovf), 0);
    idle(MAIN_W * PERIOD);
    check("R8 zero threshold never overflows", int'(ovf), 0);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; last_edge = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_min_threshold();
    t_thr_clear();
    t_long_threshold();
    t_key_clear();
    t_partial();
    t_wrong_data();
    t_other_addr();
    t_zero();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule